// File: doc/BRIEF.md
# Descriptor-Linked Display Refresh DMA

This block is a single-channel DMA engine. It copies frame memory, and optionally a palette before it, into the write port of a display controller's data FIFO. Its work is described by 16-byte descriptors that it reads from memory. Each descriptor names a source region, a fixed target address, a transfer unit size and a unit count. It can also link to a further descriptor. After the count of a descriptor is used up, the engine follows the link or stops. A descriptor that links to itself refreshes the panel without end. A descriptor with its link clear gives one pass for each doorbell.

The link bit can be changed while a pass is running, so software can move between endless refresh and refresh on demand without stopping the channel. Five sticky flags record what happened. Software clears them by writing ones. An interrupt line reports the end of a transfer when the descriptor asks for it, and reports errors at all times. The memory side is a simple read port that handles one outstanding request. The FIFO side is a write strobe with back-pressure.

Top module: `lcd_refresh_dma`

## Requirements
- R1: After reset all five flags are 0, `irq` is low, and neither `mem_req` nor `fifo_wr` is asserted.
- R2: A descriptor is four words at offsets +0 (command), +4 (source), +8 (target) and +12 (next slot in bits 31:24, unit count in bits 23:0). Command bit 0 is valid, bit 1 is link and bit 2 is the transfer-end interrupt enable. Bits 5:3 hold the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is a 16-byte burst and 4 is a 32-byte burst.
- R3: A descriptor moves exactly `count` units from a source address that rises by the unit size. A 16-byte unit gives 4 FIFO writes and a 32-byte unit gives 8 FIFO writes, taken in address order. A 1-byte or 2-byte unit gives one write: the addressed byte or halfword of its 32-bit memory word, moved down to bit 0 and zero-extended. `fifo_waddr` equals the descriptor's target on every write.
- R4: With link set, the next descriptor is fetched from {current address bits 31:12, next slot, 4'b0000}. A descriptor whose next slot points to itself repeats with no end.
- R5: With link clear, the engine stops when the count ends and sets the transfer-end flag (bit 1). Each doorbell while the engine is stopped starts one more pass. A doorbell while the engine is active is ignored.
- R6: A doorbell starts at `pal_head` when `pix_bits` <= 8 and at `frm_head` otherwise. The low 4 bits of the head address are ignored.
- R7: `chain_on` and `chain_off` set or clear the live link bit of the descriptor in progress, from the cycle after its command word is captured. If both are asserted together, `chain_off` wins.
- R8: The count-terminated flag (bit 0) is set each time a descriptor's count ends. A count of zero ends the descriptor with no FIFO write.
- R9: If the source or the target is not a multiple of the unit size, the engine sets the address-error flag (bit 2) and the halt flag (bit 4), writes nothing and stops.
- R10: A clear valid bit or a size code of 5 to 7 sets the descriptor-invalid flag (bit 3) and the halt flag (bit 4), writes nothing and stops.
- R11: Each `flag_clr` bit clears its flag one cycle later. A set event in the same cycle wins over the clear.
- R12: `irq` is high while the address-error or descriptor-invalid flag is set. It is also high after a transfer end from a descriptor whose interrupt enable was set, until flag bit 1 is cleared.
- R13: No FIFO write takes place while `fifo_full` is high. A stalled write keeps its data, so no unit is dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| doorbell | input | 1 | Start pulse, accepted only while stopped |
| pix_bits | input | 6 | Pixel depth, selects the chain head |
| pal_head | input | 32 | Palette descriptor address |
| frm_head | input | 32 | Frame descriptor address |
| chain_on | input | 1 | Set the live link bit |
| chain_off | input | 1 | Clear the live link bit |
| mem_req | output | 1 | Memory read request, one cycle per word |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| fifo_full | input | 1 | FIFO cannot accept a write |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_waddr | output | 32 | Fixed target address of the descriptor |
| flag_clr | input | 5 | Write-one-to-clear for the flags |
| flags | output | 5 | {halt, desc invalid, addr error, transfer end, count end} |
| irq | output | 1 | Interrupt request |

## Verification
Faults in the unit-word index or in the source step show up within one frame as a FIFO stream that is shifted, repeated or missing beats when compared with the memory image. A wrong live-link state shows up at the end of a pass, as extra passes or a missing stop and transfer-end flag. Errors in the error-path decisions show up as flag or `irq` values a few cycles after the descriptor's last word is fetched, together with a FIFO that should have stayed silent. Random stalls on `fifo_full` hit the hold path in every run, so a lost or doubled word breaks the stream comparison.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 24;
  localparam int NEXT_W     = 8;
  localparam int DESC_SHIFT = 4;
  localparam int PAGE_W     = NEXT_W + DESC_SHIFT;
  localparam int NFLAG      = 5;

  // command word bit positions
  localparam int B_VALID = 0;
  localparam int B_LINK  = 1;
  localparam int B_IE    = 2;
  localparam int SZ_LO   = 3;
  localparam int SZ_HI   = 5;

  // flag indices
  localparam int F_CT   = 0;
  localparam int F_TE   = 1;
  localparam int F_AE   = 2;
  localparam int F_DI   = 3;
  localparam int F_HALT = 4;

  localparam logic [2:0] SZ_BYTE   = 3'd0;
  localparam logic [2:0] SZ_HALF   = 3'd1;
  localparam logic [2:0] SZ_WORD   = 3'd2;
  localparam logic [2:0] SZ_LINE16 = 3'd3;
  localparam logic [2:0] SZ_LINE32 = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_CHECK, ST_RUN, ST_RREQ, ST_RWAIT, ST_PUSH
  } dstate_e;

  function automatic logic [5:0] unit_bytes(input logic [2:0] code);
    case (code)
      SZ_BYTE:   return 6'd1;
      SZ_HALF:   return 6'd2;
      SZ_WORD:   return 6'd4;
      SZ_LINE16: return 6'd16;
      SZ_LINE32: return 6'd32;
      default:   return 6'd0;
    endcase
  endfunction

  function automatic logic [3:0] unit_words(input logic [2:0] code);
    case (code)
      SZ_LINE16: return 4'd4;
      SZ_LINE32: return 4'd8;
      default:   return 4'd1;
    endcase
  endfunction

  function automatic logic size_ok(input logic [2:0] code);
    return code <= SZ_LINE32;
  endfunction
endpackage

// File: rtl/rdma_addr_gen.sv
module rdma_addr_gen
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] src_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [2:0]        size_in,
  input  logic              step,
  output logic [WORD_W-1:0] rd_addr,
  output logic [1:0]        lane,
  output logic              done
);
  logic [WORD_W-1:0] cur_q, cur_d;
  logic [3:0]        widx_q, widx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [2:0]        size_q, size_d;
  logic [3:0]        last_w;
  logic              unit_end;

  assign last_w   = unit_words(size_q) - 4'd1;
  assign unit_end = step && !load && (widx_q == last_w);

  always_comb begin
    cur_d  = cur_q;
    widx_d = widx_q;
    left_d = left_q;
    size_d = size_q;
    if (load) begin
      cur_d  = src_in;
      widx_d = '0;
      left_d = cnt_in;
      size_d = size_in;
    end else if (step) begin
      if (widx_q == last_w) begin
        widx_d = '0;
        cur_d  = cur_q + WORD_W'(unit_bytes(size_q));
        left_d = left_q - CNT_W'(1);
      end else begin
        widx_d = widx_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      widx_q <= '0;
      left_q <= '0;
      size_q <= SZ_WORD;
    end else if (load || step) begin
      cur_q  <= cur_d;
      widx_q <= widx_d;
      left_q <= left_d;
      size_q <= size_d;
    end
  end

  assign rd_addr = {cur_q[WORD_W-1:2], 2'b00} + WORD_W'({widx_q, 2'b00});
  assign lane    = cur_q[1:0];
  assign done    = (left_q == '0);

  a_r3_src_rises: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> cur_q == $past(cur_q) + WORD_W'(unit_bytes($past(size_q))));
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> left_q == $past(left_q) - CNT_W'(1));
endmodule

// File: rtl/rdma_status.sv
module rdma_status
  import rdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_ev,
  input  logic             te_irq_ev,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags_q,
  output logic             irq
);
  logic [NFLAG-1:0] flags_d;
  logic             te_pend_q, te_pend_d;
  logic             upd;

  always_comb begin
    flags_d   = (flags_q & ~clr) | set_ev;
    te_pend_d = te_irq_ev | (te_pend_q & ~clr[F_TE]);
    upd       = (|set_ev) || (|clr) || te_irq_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      te_pend_q <= 1'b0;
    end else if (upd) begin
      flags_q   <= flags_d;
      te_pend_q <= te_pend_d;
    end
  end

  assign irq = te_pend_q | flags_q[F_AE] | flags_q[F_DI];

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> flags_q[i]);
    a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set_ev[i]) |=> !flags_q[i]);
  end

  a_r12_te_irq_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flags_q[F_AE] && !flags_q[F_DI]) |-> flags_q[F_TE]);
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int DEPTH_W      = 6,
  parameter int PAL_MAX_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               doorbell,
  input  logic [DEPTH_W-1:0] pix_bits,
  input  logic [WORD_W-1:0]  pal_head,
  input  logic [WORD_W-1:0]  frm_head,
  input  logic               chain_on,
  input  logic               chain_off,
  output logic               mem_req,
  output logic [WORD_W-1:0]  mem_addr,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               mem_rvalid,
  input  logic               fifo_full,
  output logic               fifo_wr,
  output logic [WORD_W-1:0]  fifo_wdata,
  output logic [WORD_W-1:0]  fifo_waddr,
  output logic               agen_load,
  output logic [WORD_W-1:0]  agen_src,
  output logic [CNT_W-1:0]   agen_cnt,
  output logic [2:0]         agen_size,
  output logic               agen_step,
  input  logic [WORD_W-1:0]  agen_rd_addr,
  input  logic [1:0]         agen_lane,
  input  logic               agen_done,
  output logic [NFLAG-1:0]   set_ev,
  output logic               te_irq_ev
);
  dstate_e           state_q, state_d;
  logic [WORD_W-1:0] desc_q, desc_d;
  logic [1:0]        dw_q, dw_d;
  logic              link_q, link_d;
  logic [WORD_W-1:0] cmd_q, src_q, tgt_q, data_q;
  logic [NEXT_W-1:0] nxt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cap_desc, cap_data;
  logic [2:0]        sz;
  logic [WORD_W-1:0] ub_mask, head, next_addr;

  assign sz        = cmd_q[SZ_HI:SZ_LO];
  assign ub_mask   = WORD_W'(unit_bytes(sz)) - WORD_W'(1);
  assign head      = (pix_bits <= DEPTH_W'(PAL_MAX_BITS)) ? pal_head : frm_head;
  assign next_addr = {desc_q[WORD_W-1:PAGE_W], nxt_q, {DESC_SHIFT{1'b0}}};

  always_comb begin
    state_d   = state_q;
    desc_d    = desc_q;
    dw_d      = dw_q;
    link_d    = link_q;
    cap_desc  = 1'b0;
    cap_data  = 1'b0;
    agen_load = 1'b0;
    agen_step = 1'b0;
    mem_req   = 1'b0;
    mem_addr  = '0;
    fifo_wr   = 1'b0;
    set_ev    = '0;
    te_irq_ev = 1'b0;
    case (state_q)
      ST_IDLE: if (doorbell) begin
        desc_d  = {head[WORD_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        dw_d    = '0;
        state_d = ST_DREQ;
      end
      ST_DREQ: begin
        mem_req  = 1'b1;
        mem_addr = desc_q + WORD_W'({dw_q, 2'b00});
        state_d  = ST_DWAIT;
      end
      ST_DWAIT: if (mem_rvalid) begin
        cap_desc = 1'b1;
        if (dw_q == 2'd0) link_d = mem_rdata[B_LINK];
        if (dw_q == 2'd3) state_d = ST_CHECK;
        else begin
          dw_d    = dw_q + 2'd1;
          state_d = ST_DREQ;
        end
      end
      ST_CHECK: begin
        if (!cmd_q[B_VALID] || !size_ok(sz)) begin
          set_ev[F_DI]   = 1'b1;
          set_ev[F_HALT] = 1'b1;
          state_d        = ST_IDLE;
        end else if (((src_q | tgt_q) & ub_mask) != '0) begin
          set_ev[F_AE]   = 1'b1;
          set_ev[F_HALT] = 1'b1;
          state_d        = ST_IDLE;
        end else begin
          agen_load = 1'b1;
          state_d   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (agen_done) begin
          set_ev[F_CT] = 1'b1;
          if (link_q) begin
            desc_d  = next_addr;
            dw_d    = '0;
            state_d = ST_DREQ;
          end else begin
            set_ev[F_TE] = 1'b1;
            te_irq_ev    = cmd_q[B_IE];
            state_d      = ST_IDLE;
          end
        end else begin
          state_d = ST_RREQ;
        end
      end
      ST_RREQ: begin
        mem_req  = 1'b1;
        mem_addr = agen_rd_addr;
        state_d  = ST_RWAIT;
      end
      ST_RWAIT: if (mem_rvalid) begin
        cap_data = 1'b1;
        state_d  = ST_PUSH;
      end
      ST_PUSH: if (!fifo_full) begin
        fifo_wr   = 1'b1;
        agen_step = 1'b1;
        state_d   = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_IDLE) begin
      if (chain_on)  link_d = 1'b1;
      if (chain_off) link_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      desc_q  <= '0;
      dw_q    <= '0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      desc_q  <= desc_d;
      dw_q    <= dw_d;
      link_q  <= link_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_desc) begin
      case (dw_q)
        2'd0:    cmd_q <= mem_rdata;
        2'd1:    src_q <= mem_rdata;
        2'd2:    tgt_q <= mem_rdata;
        default: {nxt_q, cnt_q} <= mem_rdata;
      endcase
    end
    if (cap_data) data_q <= mem_rdata;
  end

  always_comb begin
    case (sz)
      SZ_BYTE: fifo_wdata = WORD_W'(8'(data_q >> {agen_lane, 3'b000}));
      SZ_HALF: fifo_wdata = WORD_W'(16'(data_q >> {agen_lane[1], 4'b0000}));
      default: fifo_wdata = data_q;
    endcase
  end

  assign fifo_waddr = tgt_q;
  assign agen_src   = src_q;
  assign agen_cnt   = cnt_q;
  assign agen_size  = sz;

  a_r13_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PUSH && fifo_full) |=> (state_q == ST_PUSH && $stable(fifo_wdata)));
  a_r9_stop_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev[F_AE] || set_ev[F_DI]) |=> (state_q == ST_IDLE && !fifo_wr));
  a_r8_ct_at_count_end: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev[F_CT] |-> agen_done);
  a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

// File: rtl/lcd_refresh_dma.sv
module lcd_refresh_dma
  import rdma_pkg::*;
#(
  parameter int DEPTH_W      = 6,
  parameter int PAL_MAX_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               doorbell,
  input  logic [DEPTH_W-1:0] pix_bits,
  input  logic [31:0]        pal_head,
  input  logic [31:0]        frm_head,
  input  logic               chain_on,
  input  logic               chain_off,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_rvalid,
  input  logic               fifo_full,
  output logic               fifo_wr,
  output logic [31:0]        fifo_wdata,
  output logic [31:0]        fifo_waddr,
  input  logic [4:0]         flag_clr,
  output logic [4:0]         flags,
  output logic               irq
);
  logic              agen_load, agen_step, agen_done, te_irq_ev;
  logic [WORD_W-1:0] agen_src, agen_rd_addr;
  logic [CNT_W-1:0]  agen_cnt;
  logic [2:0]        agen_size;
  logic [1:0]        agen_lane;
  logic [NFLAG-1:0]  set_ev;

  rdma_ctrl #(.DEPTH_W(DEPTH_W), .PAL_MAX_BITS(PAL_MAX_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .pix_bits(pix_bits),
    .pal_head(pal_head), .frm_head(frm_head),
    .chain_on(chain_on), .chain_off(chain_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_waddr(fifo_waddr),
    .agen_load(agen_load), .agen_src(agen_src), .agen_cnt(agen_cnt), .agen_size(agen_size),
    .agen_step(agen_step), .agen_rd_addr(agen_rd_addr), .agen_lane(agen_lane),
    .agen_done(agen_done), .set_ev(set_ev), .te_irq_ev(te_irq_ev)
  );

  rdma_addr_gen u_agen (
    .clk(clk), .rst_n(rst_n), .load(agen_load), .src_in(agen_src), .cnt_in(agen_cnt),
    .size_in(agen_size), .step(agen_step), .rd_addr(agen_rd_addr), .lane(agen_lane),
    .done(agen_done)
  );

  rdma_status u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .te_irq_ev(te_irq_ev),
    .clr(flag_clr), .flags_q(flags), .irq(irq)
  );
endmodule

// File: tb/lcd_refresh_dma_test.sv
module lcd_refresh_dma_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, doorbell, chain_on, chain_off, mem_rvalid, fifo_full;
  logic [5:0]  pix_bits;
  logic [31:0] pal_head, frm_head, mem_rdata;
  logic [4:0]  flag_clr;
  logic        mem_req, fifo_wr, irq;
  logic [31:0] mem_addr, fifo_wdata, fifo_waddr;
  logic [4:0]  flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_refresh_dma uut (
    .clk(clk), .rst_n(rst_n), .doorbell(doorbell), .pix_bits(pix_bits),
    .pal_head(pal_head), .frm_head(frm_head), .chain_on(chain_on), .chain_off(chain_off),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_waddr(fifo_waddr),
    .flag_clr(flag_clr), .flags(flags), .irq(irq)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] got [$];
  logic [31:0] exp_q [$];
  logic [31:0] exp_tgt;
  logic        addr_ok, stall_en, pend;
  logic [31:0] pend_data;
  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // memory responder, FIFO back-pressure and FIFO capture
  initial begin
    pend = 1'b0; pend_data = '0; mem_rvalid = 1'b0; mem_rdata = '0; fifo_full = 1'b0;
    forever begin
      @(posedge clk); #1;
      mem_rvalid = pend;
      mem_rdata  = pend_data;
      pend       = mem_req;
      pend_data  = mem[mem_addr[11:2]];
      fifo_full  = stall_en && ($urandom_range(0, 3) == 0);
      @(negedge clk);
      if (fifo_wr) begin
        got.push_back(fifo_wdata);
        if (fifo_waddr != exp_tgt) addr_ok = 1'b0;
      end
    end
  end

  function automatic int ubytes(input int sz);
    case (sz) 0: return 1; 1: return 2; 2: return 4; 3: return 16; default: return 32; endcase
  endfunction
  function automatic int uwords(input int sz);
    return (sz == 3) ? 4 : (sz == 4) ? 8 : 1;
  endfunction
  function automatic logic [31:0] beat(input int sz, input int addr, input int w);
    logic [31:0] wd;
    wd = mem[((addr & ~3) >> 2) + w];
    if (sz == 0) return (wd >> (8 * (addr % 4))) & 32'hff;
    if (sz == 1) return (wd >> (16 * ((addr >> 1) % 2))) & 32'hffff;
    return wd;
  endfunction
  function automatic logic [31:0] mkcmd(input bit v, input bit lk, input bit ie, input int sz);
    return 32'(v) | (32'(lk) << 1) | (32'(ie) << 2) | (32'(sz) << 3);
  endfunction

  task automatic put_desc(input int at, input logic [31:0] cmd, input logic [31:0] src,
                          input logic [31:0] tgt, input int nxt, input int cnt);
    mem[at >> 2]       = cmd;
    mem[(at >> 2) + 1] = src;
    mem[(at >> 2) + 2] = tgt;
    mem[(at >> 2) + 3] = (32'(nxt) << 24) | (32'(cnt) & 32'h00ff_ffff);
  endtask

  task automatic add_exp(input int sz, input int src, input int cnt);
    for (int u = 0; u < cnt; u++)
      for (int w = 0; w < uwords(sz); w++)
        exp_q.push_back(beat(sz, src + u * ubytes(sz), w));
  endtask

  task automatic clear_all();
    @(negedge clk); flag_clr = 5'h1f;
    @(negedge clk); flag_clr = 5'h00;
    got.delete(); exp_q.delete(); addr_ok = 1'b1;
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic wait_stop(input string req);
    int n = 0;
    while ((flags & 5'b01110) == 5'b0 && n < 6000) begin @(negedge clk); n++; end
    chk(n < 6000, req, "channel stop", 32'(n), 32'd6000);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int bad = -1;
    chk(got.size() == exp_q.size(), req, "beat count", 32'(got.size()), 32'(exp_q.size()));
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      if (bad < 0 && got[i] != exp_q[i]) bad = i;
    if (bad >= 0) chk(1'b0, req, "stream data", got[bad], exp_q[bad]);
    else          chk(1'b1, req, "stream data", 32'd0, 32'd0);
    chk(addr_ok, req, "target address", fifo_waddr, exp_tgt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int sz, cnt, src, ie;
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    rst_n = 1'b0; doorbell = 1'b0; chain_on = 1'b0; chain_off = 1'b0;
    pix_bits = 6'd16; pal_head = '0; frm_head = '0; flag_clr = '0;
    exp_tgt = 32'h1000; addr_ok = 1'b1; stall_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(flags == 5'b0, "R1", "flags after reset", 32'(flags), 32'd0);
    chk(!irq && !mem_req && !fifo_wr, "R1", "irq/req/wr idle", 32'({irq, mem_req, fifo_wr}), 32'd0);

    stall_en = 1'b1;
    // R2 R3 R5 R12: one word frame, link clear, interrupt enabled
    put_desc(32'h010, mkcmd(1, 0, 1, 2), 32'h400, 32'h1000, 0, 6);
    frm_head = 32'h01c;  // low bits ignored (R6)
    clear_all(); add_exp(2, 32'h400, 6);
    ring(); wait_stop("R3");
    cmp_stream("R3");
    chk(flags == 5'b00011, "R5", "count end + transfer end", 32'(flags), 32'h3);
    chk(irq == 1'b1, "R12", "irq with enable", 32'(irq), 32'd1);
    // R11 clear only transfer-end bit
    @(negedge clk); flag_clr = 5'b00010; @(negedge clk); flag_clr = 5'b0; @(negedge clk);
    chk(flags == 5'b00001, "R11", "partial clear", 32'(flags), 32'h1);
    chk(irq == 1'b0, "R12", "irq drops with flag", 32'(irq), 32'd0);

    // R5 doorbell restarts one more pass; second doorbell during pass ignored
    clear_all(); add_exp(2, 32'h400, 6);
    ring(); repeat (8) @(negedge clk); ring(); wait_stop("R5");
    cmp_stream("R5");
    repeat (20) @(negedge clk);
    chk(got.size() == 6, "R5", "no pass after stop", 32'(got.size()), 32'd6);

    // R8 count zero: completes with no writes
    put_desc(32'h020, mkcmd(1, 0, 0, 2), 32'h400, 32'h1000, 0, 0);
    frm_head = 32'h020;
    clear_all(); ring(); wait_stop("R8");
    chk(got.size() == 0, "R8", "zero count writes", 32'(got.size()), 32'd0);
    chk(flags == 5'b00011, "R8", "zero count flags", 32'(flags), 32'h3);
    chk(irq == 1'b0, "R12", "no irq without enable", 32'(irq), 32'd0);

    // R3 random descriptors of every unit size
    for (int k = 0; k < 10; k++) begin
      sz  = (k < 5) ? k : int'($urandom_range(0, 4));
      cnt = int'($urandom_range(1, 12));
      src = 32'h400 + int'($urandom_range(0, 31)) * ubytes(sz);
      ie  = int'($urandom_range(0, 1));
      put_desc(32'h030, mkcmd(1, 0, ie[0], sz), 32'(src), 32'h1000, 0, cnt);
      frm_head = 32'h030;
      clear_all(); add_exp(sz, src, cnt);
      ring(); wait_stop("R3");
      cmp_stream("R3");
      chk(irq == ie[0], "R12", "irq follows enable", 32'(irq), 32'(ie));
    end

    // R4 R7 self-linked refresh stopped by chain_off
    put_desc(32'h040, mkcmd(1, 1, 0, 2), 32'h800, 32'h1000, 8'h04, 5);
    frm_head = 32'h040;
    clear_all();
    ring();
    while (got.size() < 12) @(negedge clk);
    chk(flags[1] == 1'b0, "R4", "no stop while linked", 32'(flags), 32'h1);
    chain_off = 1'b1; @(negedge clk); chain_off = 1'b0;
    wait_stop("R7");
    chk(got.size() % 5 == 0 && got.size() >= 15, "R4", "whole passes", 32'(got.size()), 32'd15);
    for (int i = 0; i < got.size() / 5; i++) add_exp(2, 32'h800, 5);
    cmp_stream("R4");

    // R7 chain_on extends a link-clear descriptor into its next slot
    put_desc(32'h050, mkcmd(1, 0, 0, 2), 32'h900, 32'h1000, 8'h06, 6);
    put_desc(32'h060, mkcmd(1, 0, 0, 3), 32'h980, 32'h1000, 8'h00, 2);
    frm_head = 32'h050;
    clear_all(); add_exp(2, 32'h900, 6); add_exp(3, 32'h980, 2);
    ring();
    while (got.size() < 2) @(negedge clk);
    chain_on = 1'b1; @(negedge clk); chain_on = 1'b0;
    wait_stop("R7");
    cmp_stream("R7");

    // R6 palette head for shallow pixels, frame head otherwise
    put_desc(32'h080, mkcmd(1, 1, 0, 1), 32'h402, 32'h1000, 8'h09, 4);
    put_desc(32'h090, mkcmd(1, 0, 0, 4), 32'h600, 32'h1000, 8'h00, 2);
    pal_head = 32'h080; frm_head = 32'h090; pix_bits = 6'd8;
    clear_all(); add_exp(1, 32'h402, 4); add_exp(4, 32'h600, 2);
    ring(); wait_stop("R6");
    cmp_stream("R6");
    pix_bits = 6'd16;
    clear_all(); add_exp(4, 32'h600, 2);
    ring(); wait_stop("R6");
    cmp_stream("R6");

    // R9 misaligned source, then misaligned target
    put_desc(32'h0a0, mkcmd(1, 0, 0, 2), 32'h402, 32'h1000, 0, 4);
    frm_head = 32'h0a0;
    clear_all(); ring(); wait_stop("R9");
    chk(flags == 5'b10100, "R9", "source misaligned flags", 32'(flags), 32'h14);
    chk(got.size() == 0 && irq, "R9", "no data, irq up", 32'(got.size()), 32'd0);
    @(negedge clk); flag_clr = 5'b10000; @(negedge clk); flag_clr = 5'b0; @(negedge clk);
    chk(flags == 5'b00100 && irq, "R11", "halt cleared alone", 32'(flags), 32'h4);
    put_desc(32'h0a0, mkcmd(1, 0, 0, 1), 32'h400, 32'h1001, 0, 4);
    clear_all(); ring(); wait_stop("R9");
    chk(flags == 5'b10100 && got.size() == 0, "R9", "target misaligned", 32'(flags), 32'h14);

    // R10 clear valid bit, then a reserved size code
    put_desc(32'h0b0, mkcmd(0, 0, 0, 2), 32'h400, 32'h1000, 0, 4);
    frm_head = 32'h0b0;
    clear_all(); ring(); wait_stop("R10");
    chk(flags == 5'b11000 && got.size() == 0, "R10", "invalid descriptor", 32'(flags), 32'h18);
    chk(irq == 1'b1, "R12", "irq on invalid", 32'(irq), 32'd1);
    put_desc(32'h0b0, mkcmd(1, 0, 0, 6), 32'h400, 32'h1000, 0, 4);
    clear_all(); ring(); wait_stop("R10");
    chk(flags == 5'b11000 && got.size() == 0, "R10", "reserved size", 32'(flags), 32'h18);
    clear_all(); @(negedge clk);
    chk(flags == 5'b0 && !irq, "R11", "all cleared", 32'(flags), 32'd0);

    // R13 long burst with heavy stalls
    put_desc(32'h0c0, mkcmd(1, 0, 0, 4), 32'hA00, 32'h1000, 0, 10);
    frm_head = 32'h0c0;
    clear_all(); add_exp(4, 32'hA00, 10);
    ring(); wait_stop("R13");
    cmp_stream("R13");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule